// File: doc/BRIEF.md
# Dual-Width Stack Push/Pop Sequencer

This unit performs stack accesses for a core whose stack runs either with a full 32-bit pointer or with a 16-bit pointer. For each request it forms the linear address by adding the stack segment base to the pointer. It moves 16-bit or 32-bit data through a memory port that answers each access with an acknowledge and a fault flag. It then writes the new pointer back to the register file. The data width and the stack mode are independent inputs.

The pointer is written back only when memory accepted the access without a fault. A faulting access ends the request with a fault pulse and leaves the pointer register untouched.

A third request type stores all eight general registers as one frame. The unit first probes the whole frame region below the pointer in a single memory transaction. It then pushes the registers in index order. In place of the pointer register it stores the pointer value captured when the request was accepted.

Top module: `stk_engine`

## Requirements
- R1: A push (`req_op`=00) writes to segment base plus (pointer − 2) when `req_wide`=0 and to segment base plus (pointer − 4) when `req_wide`=1, whichever stack mode is selected. A narrow push writes the low 16 bits of `push_data`, zero-extended. The transaction has `mem_we`=1, `mem_probe`=0, and `mem_len` set to the byte count.
- R2: With `req_big`=0, the pointer plus offset is reduced to its low 16 bits before the base is added. With `req_big`=1, the full 32-bit sum is used without masking.
- R3: The pointer write port (`sp_wr_en`) pulses only after an acknowledge without fault. A faulting push, pop or frame store ends with a one-cycle `fault` pulse and no further pointer write.
- R4: A pop (`req_op`=01) reads at segment base plus the current pointer (`mem_we`=0) and returns the data on `pop_data`, with the low 16 bits zero-extended when narrow. It advances the pointer by 2 or 4. With `req_big`=0 only the low 16 bits change, wrapping modulo 2^16, and the upper 16 bits of the register are kept.
- R5: A frame store (`req_op`=10) first issues one transaction with `mem_probe`=1 and `mem_we`=1. Its address is base plus (pointer − 16) for narrow or (pointer − 32) for wide, masked as in R2, and `mem_len` is 16 or 32. A fault on this probe ends the request with no register write to memory and no pointer change.
- R6: After a clean probe, the frame store pushes register indexes 0 to 7 in that order, each at the next lower slot as in R1. For index 4 it stores the pointer captured at acceptance instead of the register. The pointer is written back after each clean slot, so a fault at slot k leaves the pointer k slots below the start.
- R7: `busy` is high from acceptance to completion. A request while `busy` is high is ignored, and `req_op`=11 is never accepted.
- R8: Every accepted request ends with exactly one one-cycle pulse, either `done` or `fault`.
- R9: `mem_req` stays high with a stable address and direction until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 push, 01 pop, 10 frame store, 11 none |
| req_wide | input | 1 | 1: 32-bit data, 0: 16-bit data |
| req_big | input | 1 | 1: 32-bit pointer, 0: 16-bit pointer |
| seg_base | input | 32 | Stack segment base |
| push_data | input | 32 | Data for a single push |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Fault pulse |
| pop_data | output | 32 | Data of the last clean pop |
| sp_value | input | 32 | Current stack pointer register |
| sp_wr_en | output | 1 | Pointer write strobe |
| sp_wr_data | output | 32 | New pointer register value |
| rf_rd_idx | output | 3 | Register index read during the frame store |
| rf_rd_data | input | 32 | Register read data |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 write or probe, 0 read |
| mem_probe | output | 1 | Writability check of a region, no data |
| mem_len | output | 6 | Byte count of the transaction |
| mem_addr | output | 32 | Linear address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction complete |
| mem_fault | input | 1 | Fault, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench targets pointers just above zero and just below 2^16 in both stack modes. A design that masks in the wrong mode sends the access far from the segment base, or it corrupts the upper pointer half.

Faults are injected on single accesses, on the frame probe and in mid-frame. A design that commits the pointer before the acknowledge, or that skips the probe, shows the wrong pointer or extra writes.

The frame store is checked for slot order and for the captured pointer value. A design that reads the live pointer register stores an already-decremented value. Requests sent while the unit is busy, and the unused operation code, must produce no extra transaction and no extra completion pulse.

// File: rtl/stk_pkg.sv
// Package: shared types of the stack sequencer.
// Assumes: operation encoding fixed by the request port (2 bits).
package stk_pkg;

    // Request operation codes as seen on req_op.
    typedef enum logic [1:0] {
        OP_PUSH    = 2'b00,
        OP_POP     = 2'b01,
        OP_PUSHALL = 2'b10,
        OP_NONE    = 2'b11
    } stk_op_e;

    // Sequencer states; ST_SLOT repeats once per register slot.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_PROBE  = 2'd2,
        ST_SLOT   = 2'd3
    } stk_state_e;

endpackage

// File: rtl/stk_ptr_calc.sv
// Module: stk_ptr_calc
// Forms the linear access address and the next pointer register value
// from a pointer and two offsets. In narrow-stack mode, the sum is cut to
// WRAP_W bits before the base is added, and the upper pointer bits are kept.
// Assumes: offsets are two's complement in PW bits.
module stk_ptr_calc #(
    parameter int PW     = 32,
    parameter int WRAP_W = 16
) (
    input  logic          big,
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] acc_off,
    input  logic [PW-1:0] nxt_off,
    output logic [PW-1:0] lin,
    output logic [PW-1:0] nxt
);
    localparam int UP_W = PW - WRAP_W;

    logic [PW-1:0] acc_sum;
    logic [PW-1:0] acc_view;
    logic [PW-1:0] nxt_sum;

    // Access address: pointer plus offset, wrapped in narrow mode, plus base.
    always_comb begin
        acc_sum  = ptr + acc_off;
        acc_view = big ? acc_sum : {{UP_W{1'b0}}, acc_sum[WRAP_W-1:0]};
        lin      = base + acc_view;
    end

    // Next pointer: full sum in wide mode, low half replaced in narrow mode.
    always_comb begin
        nxt_sum = ptr + nxt_off;
        nxt     = big ? nxt_sum : {ptr[PW-1:WRAP_W], nxt_sum[WRAP_W-1:0]};
    end

endmodule

// File: rtl/stk_wdata_sel.sv
// Module: stk_wdata_sel
// Picks the write data: push data for single pushes, the register file
// for frame slots, and the captured pointer in the pointer slot.
// Narrow accesses are zero-extended from the low half.
// Assumes: rf_rd_data is a combinational read of index slot_idx.
module stk_wdata_sel #(
    parameter int PW      = 32,
    parameter int SLOT_W  = 3,
    parameter int SP_SLOT = 4
) (
    input  logic              in_slot,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              wide,
    input  logic [PW-1:0]     rf_rd_data,
    input  logic [PW-1:0]     orig_ptr,
    input  logic [PW-1:0]     data_r,
    output logic [PW-1:0]     wdata
);
    localparam int HALF_W = PW / 2;

    logic [PW-1:0] raw;

    // Source select, then width trim.
    always_comb begin
        if (!in_slot)
            raw = data_r;
        else if (slot_idx == SLOT_W'(SP_SLOT))
            raw = orig_ptr;
        else
            raw = rf_rd_data;
        wdata = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end

endmodule

// File: rtl/stk_seq.sv
// Module: stk_seq
// Control of the stack unit: accepts one request when idle, drives the memory
// handshake, commits the pointer only after a clean acknowledge, and walks
// the probe plus NREGS slots of the frame store.
// Assumes: mem_ack comes while mem_req is high; mem_fault is valid with it.
module stk_seq
    import stk_pkg::*;
#(
    parameter int PW     = 32,
    parameter int WRAP_W = 16,
    parameter int NREGS  = 8,
    parameter int SLOT_W = 3,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_wide,
    input  logic              req_big,
    input  logic [PW-1:0]     seg_base,
    input  logic [PW-1:0]     push_data,
    input  logic [PW-1:0]     sp_value,
    input  logic              mem_ack,
    input  logic              mem_fault,
    input  logic [PW-1:0]     mem_rdata,
    input  logic [PW-1:0]     nxt_ptr,
    output logic [PW-1:0]     cur_ptr,
    output logic [PW-1:0]     orig_ptr,
    output logic [PW-1:0]     base_r,
    output logic [PW-1:0]     data_r,
    output logic              big_r,
    output logic              wide_r,
    output logic [PW-1:0]     acc_off,
    output logic [PW-1:0]     nxt_off,
    output logic              in_slot,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_probe,
    output logic [LEN_W-1:0]  mem_len,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              sp_wr_en,
    output logic [PW-1:0]     sp_wr_data,
    output logic [PW-1:0]     pop_data
);
    localparam int            HALF_W   = PW / 2;
    localparam logic [PW-1:0] WIDE_B   = PW'(PW / 8);
    localparam logic [PW-1:0] NARROW_B = PW'(PW / 16);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NREGS - 1);

    stk_state_e        state;
    stk_op_e           op_r;
    logic [SLOT_W-1:0] slot_r;
    logic [PW-1:0]     sz;
    logic [PW-1:0]     frame;
    logic              is_pop;

    // Access size and frame size from the latched width.
    always_comb begin
        sz     = wide_r ? WIDE_B : NARROW_B;
        frame  = sz * PW'(NREGS);
        is_pop = (state == ST_SINGLE) && (op_r == OP_POP);
    end

    // Offsets fed to the pointer calculator for the current state.
    always_comb begin
        case (state)
            ST_SINGLE: acc_off = is_pop ? '0 : ('0 - sz);
            ST_PROBE:  acc_off = '0 - frame;
            default:   acc_off = '0 - sz;
        endcase
        nxt_off = is_pop ? sz : ('0 - sz);
    end

    // Memory port and status decode from the state.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = !is_pop;
        mem_probe = (state == ST_PROBE);
        mem_len   = LEN_W'((state == ST_PROBE) ? frame : sz);
        busy      = (state != ST_IDLE);
        in_slot   = (state == ST_SLOT);
        slot_idx  = slot_r;
    end

    // Request acceptance, handshake progress and pointer commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_r       <= OP_PUSH;
            wide_r     <= 1'b0;
            big_r      <= 1'b0;
            base_r     <= '0;
            data_r     <= '0;
            cur_ptr    <= '0;
            orig_ptr   <= '0;
            slot_r     <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            sp_wr_en   <= 1'b0;
            sp_wr_data <= '0;
            pop_data   <= '0;
        end else begin
            done     <= 1'b0;
            fault    <= 1'b0;
            sp_wr_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid && (req_op != OP_NONE)) begin
                        op_r     <= stk_op_e'(req_op);
                        wide_r   <= req_wide;
                        big_r    <= req_big;
                        base_r   <= seg_base;
                        data_r   <= push_data;
                        cur_ptr  <= sp_value;
                        orig_ptr <= sp_value;
                        slot_r   <= '0;
                        state    <= (req_op == OP_PUSHALL) ? ST_PROBE : ST_SINGLE;
                    end
                end
                ST_SINGLE: begin
                    if (mem_ack) begin
                        state <= ST_IDLE;
                        if (mem_fault) begin
                            fault <= 1'b1;
                        end else begin
                            done       <= 1'b1;
                            sp_wr_en   <= 1'b1;
                            sp_wr_data <= nxt_ptr;
                            if (op_r == OP_POP)
                                pop_data <= wide_r ? mem_rdata
                                                   : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
                        end
                    end
                end
                ST_PROBE: begin
                    if (mem_ack) begin
                        if (mem_fault) begin
                            fault <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_SLOT;
                        end
                    end
                end
                ST_SLOT: begin
                    if (mem_ack) begin
                        if (mem_fault) begin
                            fault <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            sp_wr_en   <= 1'b1;
                            sp_wr_data <= nxt_ptr;
                            cur_ptr    <= nxt_ptr;
                            if (slot_r == LAST_SLOT) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                slot_r <= slot_r + 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |-> $past(mem_ack && !mem_fault)); // R3
    AST_FAULT_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(mem_ack && mem_fault)); // R3
    AST_OUTCOME_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> $past(mem_ack)); // R8
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !big_r) |-> (sp_wr_data[PW-1:WRAP_W] == orig_ptr[PW-1:WRAP_W])); // R4
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(orig_ptr)); // R7

endmodule

// File: rtl/stk_engine.sv
// Module: stk_engine (top)
// Stack push/pop/frame-store unit with 16- or 32-bit pointer mode.
// Wires the control sequencer, the address/pointer calculator and the
// write data selector to the register file and memory ports.
// Assumes: sp_value and rf_rd_data are combinational register file reads.
module stk_engine #(
    parameter int PW      = 32,
    parameter int WRAP_W  = 16,
    parameter int NREGS   = 8,
    parameter int SP_SLOT = 4,
    localparam int SLOT_W = $clog2(NREGS),
    localparam int LEN_W  = $clog2(NREGS * (PW / 8)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_wide,
    input  logic              req_big,
    input  logic [PW-1:0]     seg_base,
    input  logic [PW-1:0]     push_data,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [PW-1:0]     pop_data,
    input  logic [PW-1:0]     sp_value,
    output logic              sp_wr_en,
    output logic [PW-1:0]     sp_wr_data,
    output logic [SLOT_W-1:0] rf_rd_idx,
    input  logic [PW-1:0]     rf_rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_probe,
    output logic [LEN_W-1:0]  mem_len,
    output logic [PW-1:0]     mem_addr,
    output logic [PW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_fault,
    input  logic [PW-1:0]     mem_rdata
);
    logic [PW-1:0]     cur_ptr;
    logic [PW-1:0]     orig_ptr;
    logic [PW-1:0]     base_r;
    logic [PW-1:0]     data_r;
    logic              big_r;
    logic              wide_r;
    logic [PW-1:0]     acc_off;
    logic [PW-1:0]     nxt_off;
    logic [PW-1:0]     nxt_ptr;
    logic              in_slot;
    logic [SLOT_W-1:0] slot_idx;

    stk_seq #(
        .PW(PW), .WRAP_W(WRAP_W), .NREGS(NREGS), .SLOT_W(SLOT_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_wide(req_wide), .req_big(req_big),
        .seg_base(seg_base), .push_data(push_data), .sp_value(sp_value),
        .mem_ack(mem_ack), .mem_fault(mem_fault), .mem_rdata(mem_rdata),
        .nxt_ptr(nxt_ptr),
        .cur_ptr(cur_ptr), .orig_ptr(orig_ptr), .base_r(base_r), .data_r(data_r),
        .big_r(big_r), .wide_r(wide_r), .acc_off(acc_off), .nxt_off(nxt_off),
        .in_slot(in_slot), .slot_idx(slot_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_probe(mem_probe), .mem_len(mem_len),
        .busy(busy), .done(done), .fault(fault),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .pop_data(pop_data)
    );

    stk_ptr_calc #(
        .PW(PW), .WRAP_W(WRAP_W)
    ) u_calc (
        .big(big_r), .base(base_r), .ptr(cur_ptr),
        .acc_off(acc_off), .nxt_off(nxt_off),
        .lin(mem_addr), .nxt(nxt_ptr)
    );

    stk_wdata_sel #(
        .PW(PW), .SLOT_W(SLOT_W), .SP_SLOT(SP_SLOT)
    ) u_wsel (
        .in_slot(in_slot), .slot_idx(slot_idx), .wide(wide_r),
        .rf_rd_data(rf_rd_data), .orig_ptr(orig_ptr), .data_r(data_r),
        .wdata(mem_wdata)
    );

    // Register file index follows the frame slot.
    assign rf_rd_idx = slot_idx;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
    AST_NARROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !big_r) |-> ((mem_addr - base_r) < (PW'(1) << WRAP_W))); // R2
    AST_PROBE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_probe |-> (mem_we && mem_req)); // R5

endmodule

// File: tb/stk_engine_tb.sv
module stk_engine_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_wide, req_big;
    logic [1:0]  req_op;
    logic [31:0] seg_base, push_data;
    logic        busy, done, fault;
    logic [31:0] pop_data, sp_value, sp_wr_data, rf_rd_data;
    logic        sp_wr_en;
    logic [2:0]  rf_rd_idx;
    logic        mem_req, mem_we, mem_probe;
    logic [5:0]  mem_len;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack, mem_fault;

    stk_engine u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wide(req_wide), .req_big(req_big), .seg_base(seg_base), .push_data(push_data),
        .busy(busy), .done(done), .fault(fault), .pop_data(pop_data),
        .sp_value(sp_value), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_probe(mem_probe), .mem_len(mem_len),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_fault(mem_fault), .mem_rdata(mem_rdata)
    );

    // Register file model
    logic [31:0] rf [0:7];
    logic [31:0] sp_model, sp_set_val;
    logic        sp_set;
    always @(posedge clk) begin
        if (sp_set) sp_model <= sp_set_val;
        else if (sp_wr_en) sp_model <= sp_wr_data;
    end
    assign sp_value   = sp_model;
    assign rf_rd_data = (rf_rd_idx == 3'd4) ? sp_model : rf[rf_rd_idx];

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
    endfunction
    function automatic logic [31:0] msk(input logic big, input logic [31:0] v);
        return big ? v : {16'h0, v[15:0]};
    endfunction
    function automatic logic [31:0] mrg(input logic big, input logic [31:0] old, input logic [31:0] nv);
        return big ? nv : {old[31:16], nv[15:0]};
    endfunction

    // Memory model with random latency and indexed fault injection
    int          acc_total, op_start, flt_idx, dly, hold_bad, hold_seen;
    logic [31:0] lg_addr [0:63];
    logic [31:0] lg_data [0:63];
    logic        lg_we [0:63];
    logic        lg_probe [0:63];
    logic [5:0]  lg_len [0:63];
    logic [31:0] prev_addr;
    logic        prev_wait;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_fault <= 1'b0; mem_rdata <= '0;
            dly <= 0; acc_total <= 0; prev_wait <= 1'b0; hold_bad <= 0; hold_seen <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; mem_fault <= 1'b0; prev_wait <= 1'b0;
        end else if (mem_req) begin
            if (prev_wait) begin
                hold_seen <= hold_seen + 1;
                if (prev_addr !== mem_addr) hold_bad <= hold_bad + 1;
            end
            if (dly > 0) begin
                dly <= dly - 1; prev_wait <= 1'b1; prev_addr <= mem_addr;
            end else begin
                mem_ack   <= 1'b1;
                mem_fault <= (flt_idx >= 0) && ((acc_total - op_start) == flt_idx);
                mem_rdata <= rd_fn(mem_addr);
                lg_addr[acc_total & 63]  <= mem_addr;
                lg_data[acc_total & 63]  <= mem_wdata;
                lg_we[acc_total & 63]    <= mem_we;
                lg_probe[acc_total & 63] <= mem_probe;
                lg_len[acc_total & 63]   <= mem_len;
                acc_total <= acc_total + 1;
                dly <= int'($urandom_range(0, 2));
                prev_wait <= 1'b0;
            end
        end
    end

    int done_cnt, fault_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin done_cnt <= 0; fault_cnt <= 0; end
        else begin
            if (done)  done_cnt  <= done_cnt + 1;
            if (fault) fault_cnt <= fault_cnt + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] e_addr [0:8];
    logic [31:0] e_data [0:8];
    logic        e_we [0:8];
    logic        e_probe [0:8];
    logic [5:0]  e_len [0:8];

    task automatic set_sp(input logic [31:0] v);
        @(negedge clk); sp_set = 1'b1; sp_set_val = v;
        @(negedge clk); sp_set = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic wide, input logic big,
                          input logic [31:0] base, input logic [31:0] data,
                          input int fi, input bit spam);
        logic [31:0] old, sz, exp_sp;
        int ne, n, d0, f0, cyc;
        bit flt;
        old = sp_model;
        sz  = wide ? 32'd4 : 32'd2;
        if (op == 2'b10) begin
            ne = 9;
            e_addr[0] = base + msk(big, old - 8 * sz); e_we[0] = 1'b1; e_probe[0] = 1'b1;
            e_len[0] = 6'(8 * sz); e_data[0] = '0;
            for (int k = 0; k < 8; k++) begin
                logic [31:0] v;
                v = (k == 4) ? old : rf[k];
                e_addr[k+1]  = base + msk(big, old - 32'(k + 1) * sz);
                e_data[k+1]  = wide ? v : {16'h0, v[15:0]};
                e_we[k+1]    = 1'b1; e_probe[k+1] = 1'b0; e_len[k+1] = 6'(sz);
            end
        end else begin
            ne = 1;
            e_addr[0]  = (op == 2'b01) ? base + msk(big, old) : base + msk(big, old - sz);
            e_we[0]    = (op == 2'b00); e_probe[0] = 1'b0; e_len[0] = 6'(sz);
            e_data[0]  = wide ? data : {16'h0, data[15:0]};
        end
        flt = (fi >= 0) && (fi < ne);
        n   = flt ? fi + 1 : ne;
        case (op)
            2'b00:   exp_sp = flt ? old : mrg(big, old, old - sz);
            2'b01:   exp_sp = flt ? old : mrg(big, old, old + sz);
            default: exp_sp = !flt ? mrg(big, old, old - 8 * sz)
                            : (fi == 0 ? old : mrg(big, old, old - 32'(fi - 1) * sz));
        endcase
        flt_idx  = flt ? fi : -1;
        op_start = acc_total;
        d0 = done_cnt; f0 = fault_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wide = wide; req_big = big;
        seg_base = base; push_data = data;
        @(negedge clk);
        if (spam) begin
            req_op = 2'b00; push_data = ~data;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        cyc = 0;
        while ((done_cnt + fault_cnt) == (d0 + f0) && cyc < 400) begin
            @(negedge clk); cyc++;
        end
        repeat (2) @(negedge clk);
        chk(32'(done_cnt - d0), flt ? 32'd0 : 32'd1, "R8 done pulses");
        chk(32'(fault_cnt - f0), flt ? 32'd1 : 32'd0, "R3 R8 fault pulses");
        chk(32'(acc_total - op_start), 32'(n), spam ? "R7 access count while busy" : "R5 R6 access count");
        for (int i = 0; i < n; i++) begin
            int j;
            string tg;
            j  = (op_start + i) & 63;
            tg = (op == 2'b10) ? (i == 0 ? "R5 probe" : "R6 slot")
                               : (op == 2'b01 ? "R4 R2 pop" : "R1 R2 push");
            chk(lg_addr[j], e_addr[i], {tg, " addr"});
            chk(32'(lg_we[j]), 32'(e_we[i]), {tg, " dir"});
            chk(32'(lg_probe[j]), 32'(e_probe[i]), {tg, " probe flag"});
            chk(32'(lg_len[j]), 32'(e_len[i]), {tg, " len"});
            if (e_we[i] && !e_probe[i]) chk(lg_data[j], e_data[i], {tg, " data"});
        end
        chk(sp_model, exp_sp, "R3 R4 R6 pointer after request");
        if (op == 2'b01 && !flt)
            chk(pop_data, wide ? rd_fn(e_addr[0]) : {16'h0, rd_fn(e_addr[0])[15:0]}, "R4 pop data");
    endtask

    initial begin
        int a0, d0, seed;
        seed = int'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_wide = 1'b0; req_big = 1'b0;
        seg_base = '0; push_data = '0; sp_set = 1'b0; sp_set_val = '0; flt_idx = -1; op_start = 0;
        for (int k = 0; k < 8; k++) rf[k] = 32'h1111_1111 * (k + 1) ^ 32'h0F0F_3C3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(busy), 32'd0, "R7 busy after reset");
        chk(32'(mem_req), 32'd0, "R9 mem_req after reset");
        chk(32'(done), 32'd0, "R8 done after reset");
        chk(32'(fault), 32'd0, "R8 fault after reset");
        chk(32'(sp_wr_en), 32'd0, "R3 sp_wr_en after reset");

        // Directed corners
        set_sp(32'h1234_0001); run_op(2'b00, 1'b0, 1'b0, 32'h0010_0000, 32'hABCD_1234, -1, 0); // R2 wrap down
        set_sp(32'h0000_0002); run_op(2'b00, 1'b1, 1'b1, 32'h0000_1000, 32'hDEAD_BEEF, -1, 0); // R2 no mask
        set_sp(32'h5555_FFFE); run_op(2'b01, 1'b1, 1'b0, 32'h0200_0000, 32'h0, -1, 0);         // R4 wrap up
        set_sp(32'h0000_FFFE); run_op(2'b01, 1'b0, 1'b1, 32'h0000_0000, 32'h0, -1, 0);         // R4 carry
        set_sp(32'h0000_8000); run_op(2'b00, 1'b1, 1'b0, 32'h0000_4000, 32'h1357_9BDF, 0, 0);  // R3 push fault
        set_sp(32'h0001_0010); run_op(2'b01, 1'b0, 1'b0, 32'h0000_4000, 32'h0, 0, 0);          // R3 pop fault
        set_sp(32'h7777_0008); run_op(2'b10, 1'b0, 1'b0, 32'h0030_0000, 32'h0, -1, 0);         // R5 R6 wrap
        set_sp(32'h0000_1000); run_op(2'b10, 1'b1, 1'b1, 32'h0000_0000, 32'h0, 0, 0);          // R5 probe fault
        set_sp(32'h0000_2000); run_op(2'b10, 1'b1, 1'b0, 32'h0100_0000, 32'h0, 6, 0);          // R6 mid fault
        set_sp(32'h0000_3000); run_op(2'b10, 1'b1, 1'b1, 32'h0000_0000, 32'h2468_ACE0, -1, 1); // R7 busy

        // R7: unused op code is not accepted
        a0 = acc_total; d0 = done_cnt + fault_cnt;
        @(negedge clk); req_valid = 1'b1; req_op = 2'b11;
        @(negedge clk); req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(32'(acc_total - a0), 32'd0, "R7 op 11 no access");
        chk(32'(done_cnt + fault_cnt - d0), 32'd0, "R7 op 11 no completion");
        chk(32'(busy), 32'd0, "R7 op 11 not busy");

        // Constrained random
        for (int t = 0; t < 150; t++) begin
            logic [1:0] op;
            logic [31:0] r;
            int fi;
            op = 2'($urandom_range(0, 2));
            r  = $urandom;
            case ($urandom_range(0, 3))
                0: r = {r[31:16], 16'h0002};
                1: r = {r[31:16], 16'hFFFC};
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0)
                for (int k = 0; k < 8; k++) rf[k] = $urandom;
            fi = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, (op == 2'b10) ? 8 : 0)) : -1;
            set_sp(r);
            run_op(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom, $urandom, fi, 0);
        end

        chk(32'(hold_bad), 32'd0, "R9 address moved while waiting");
        chk(32'(hold_seen > 0), 32'd1, "R9 wait cycles exercised");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule